// File: doc/BRIEF.md
# Circular Return Address Stack

This block keeps the return addresses of a small processor core: eight entries of thirteen bits each. When the core takes a subroutine call or accepts an interrupt, it asserts the push strobe with the current program counter on the push data input. When it executes a return-type instruction, it asserts the pop strobe and loads the pop data output into its program counter in that same cycle.

The stack pointer lives inside the block. No port reads or writes it, and the storage is not mapped into any address space. There are no full or empty indications. A push into a full stack overwrites the oldest entry. A pop from an empty stack wraps the pointer and returns whatever entry it then addresses. The instruction decoder decides when to push or pop; this block does not.

Top module: `ret_stack`

## Requirements
- R1: Synchronous active-high reset sets the internal pointer to zero. After reset, a push of a value followed by a pop returns that value. Entry contents are not defined until they are written.
- R2: For up to 8 outstanding entries, pops return the pushed values in reverse order of pushing.
- R3: `top_addr` always shows the entry just below the pointer, and it does so without a register stage. In the cycle after a push, it equals the value pushed. While `pop_en` is high, it already holds the value being popped in that same cycle.
- R4: A push into a stack that holds 8 entries overwrites the oldest entry. After 9 pushes v0..v8, the pops return v8, v7, ..., v1 and then v8 again.
- R5: Pops past the bottom wrap around. After 8 pushes v0..v7, pops return v7..v0, and the ninth pop returns v7 again, the same as the first pop.
- R6: If push and pop are asserted in the same cycle, the push alone takes effect and the pop is ignored.
- R7: In a cycle with neither strobe asserted, the pointer and all entries keep their values, so `top_addr` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_en | input | 1 | Write `push_addr` at the pointer, then advance the pointer |
| push_addr | input | 13 | Return address to save |
| pop_en | input | 1 | Move the pointer back by one entry |
| top_addr | output | 13 | Entry just below the pointer (the value a pop returns) |

## Verification
A wrong pointer shows up at `top_addr` on the first pop after the fault, or in the cycle straight after a push, because that output is always addressed by the pointer minus one. An off-by-one in the wrap logic only shows once a run of pushes or pops crosses the 8-entry boundary. For that reason, the push and pop depths are swept past 8 in both directions. A write to the wrong slot stays hidden until the stack unwinds to that slot, so each sweep pops through every entry it wrote.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/ret_stack_ctl.sv
module ret_stack_ctl
  import ret_stack_pkg::*;
(
  input  logic    push_en,
  input  logic    pop_en,
  output stk_op_e op,
  output logic    wr_en
);
  // push wins over a simultaneous pop
  always_comb begin
    if (push_en)     op = STK_PUSH;
    else if (pop_en) op = STK_POP;
    else             op = STK_IDLE;
  end
  assign wr_en = (op == STK_PUSH);
endmodule

// File: rtl/ret_stack_ptr.sv
module ret_stack_ptr
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_op_e       op,
  output logic [PW-1:0] ptr_q,
  output logic [PW-1:0] below
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  logic [PW-1:0] inc, dec;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      // natural wrap of the counter gives modulo DEPTH
      assign inc = ptr_q + 1'b1;
      assign dec = ptr_q - 1'b1;
    end else begin : g_mod
      assign inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      assign dec = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    end
  endgenerate

  assign below = dec;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else begin
      case (op)
        STK_PUSH: ptr_q <= inc;
        STK_POP:  ptr_q <= dec;
        default:  ptr_q <= ptr_q;
      endcase
    end
  end
endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 13,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [PW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data
);
  // no reset, asynchronous read: maps onto distributed RAM
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_en,
  input  logic [WIDTH-1:0] push_addr,
  input  logic             pop_en,
  output logic [WIDTH-1:0] top_addr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  stk_op_e       op;
  logic          wr_en;
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] below;

  ret_stack_ctl u_ctl (
    .push_en (push_en),
    .pop_en  (pop_en),
    .op      (op),
    .wr_en   (wr_en)
  );

  ret_stack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .ptr_q (ptr_q),
    .below (below)
  );

  ret_stack_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (ptr_q),
    .wr_data (push_addr),
    .rd_idx  (below),
    .rd_data (top_addr)
  );
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 13,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             push_en,
  input logic [WIDTH-1:0] push_addr,
  input logic             pop_en,
  input logic [WIDTH-1:0] top_addr,
  input logic [PW-1:0]    ptr_q
);
  p_reset_ptr_r1: assert property (@(posedge clk)
    rst |=> ptr_q == '0);

  p_push_advance_r2: assert property (@(posedge clk) disable iff (rst)
    push_en |=> (32'(ptr_q) == (32'($past(ptr_q)) + 1) % DEPTH));

  p_pop_retreat_r5: assert property (@(posedge clk) disable iff (rst)
    (pop_en && !push_en) |=> (32'(ptr_q) == (32'($past(ptr_q)) + DEPTH - 1) % DEPTH));

  p_top_after_push_r3: assert property (@(posedge clk) disable iff (rst)
    push_en |=> top_addr == $past(push_addr));

  p_push_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (push_en && pop_en) |=> top_addr == $past(push_addr));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!push_en && !pop_en) |=> ($stable(ptr_q) && $stable(top_addr)));
endmodule

bind ret_stack ret_stack_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .push_en   (push_en),
  .push_addr (push_addr),
  .pop_en    (pop_en),
  .top_addr  (top_addr),
  .ptr_q     (ptr_q)
);

// File: tb/ret_stack_bench.sv
`timescale 1ns/1ps
module ret_stack_bench;
  localparam int DEPTH = 8;
  localparam int WIDTH = 13;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             push_en = 1'b0;
  logic             pop_en = 1'b0;
  logic [WIDTH-1:0] push_addr = '0;
  logic [WIDTH-1:0] top_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ret_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ret_stack (
    .clk       (clk),
    .rst       (rst),
    .push_en   (push_en),
    .push_addr (push_addr),
    .pop_en    (pop_en),
    .top_addr  (top_addr)
  );

  function automatic logic [WIDTH-1:0] val(input int seed, input int i);
    return WIDTH'((seed * 311 + i * 97 + 5) ^ (i << 7));
  endfunction

  task automatic check(input string req, input logic [WIDTH-1:0] got,
                       input logic [WIDTH-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic do_push(input logic [WIDTH-1:0] v);
    push_en = 1'b1; push_addr = v;
    @(posedge clk); @(negedge clk);
    push_en = 1'b0;
  endtask

  task automatic do_pop(input string req, input logic [WIDTH-1:0] exp);
    pop_en = 1'b1;
    #1 check(req, top_addr, exp);
    @(posedge clk); @(negedge clk);
    pop_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: push then pop right after reset
    do_push(13'h0abc);
    do_pop("R1", 13'h0abc);

    // R2: LIFO for every depth 1..8; R3 top shown the cycle after a push
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++) begin
        do_push(val(n, i));
        #1 check("R3", top_addr, val(n, i));
      end
      for (int j = 0; j < n; j++) do_pop("R2", val(n, n - 1 - j));
    end

    // R4: overflow, depths 9..16, then 8 pops
    for (int n = DEPTH + 1; n <= 2 * DEPTH; n++) begin
      for (int i = 0; i < n; i++) do_push(val(100 + n, i));
      for (int j = 0; j < DEPTH; j++) do_pop("R4", val(100 + n, n - 1 - j));
    end
    // R4: nine pushes then nine pops, ninth repeats the first
    for (int i = 0; i < 9; i++) do_push(val(200, i));
    for (int j = 0; j < 8; j++) do_pop("R4", val(200, 8 - j));
    do_pop("R4", val(200, 8));

    // R5: underflow wrap, 8 pushes then 9..16 pops
    for (int p = DEPTH + 1; p <= 2 * DEPTH; p++) begin
      for (int i = 0; i < DEPTH; i++) do_push(val(300 + p, i));
      for (int j = 0; j < p; j++) do_pop("R5", val(300 + p, DEPTH - 1 - (j % DEPTH)));
    end

    // R6: simultaneous push and pop acts as push
    do_push(13'h1111);
    push_en = 1'b1; pop_en = 1'b1; push_addr = 13'h0222;
    @(posedge clk); @(negedge clk);
    push_en = 1'b0; pop_en = 1'b0;
    #1 check("R6", top_addr, 13'h0222);
    do_pop("R6", 13'h0222);
    do_pop("R6", 13'h1111);

    // R7: idle cycles hold the top entry
    do_push(13'h1e5a);
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); @(negedge clk);
      check("R7", top_addr, 13'h1e5a);
    end
    do_pop("R7", 13'h1e5a);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule